// File: doc/BRIEF.md
# Power-Good Strap Latch Controller

This block sits in the reference clock domain of a clock generator and turns a handful of slow board-level pins into clean per-output enable controls. One shared pin acts first as a power-good strobe. On its first high level, the block captures the frequency-select code and the configuration straps. It holds them until the next reset, which marks a power cycle. From then on the same pin is read as an active-low power-down request.

The latched straps do three jobs. They give a CPU frequency index. They decide whether two dual-function pins carry an extra SRC clock or act as the CPU and PCI stop inputs. They decide whether one differential pair carries a CPU debug clock or the SRC8 clock. A test-select strap enters a test mode. In that mode a live test pin chooses between driving every output from the divided reference and floating every output. When a register-controlled clock-request mode is on, four active-low request inputs gate chosen SRC outputs.

All pin inputs pass through a synchronizer first. Each enable changes only in a cycle in which its clock is reported low, so that gating never cuts a pulse short. The reset input is expected to be released synchronously by the surrounding logic.

Top module: `pgs_strap_ctrl`

## Requirements
- R1: While reset is asserted, and until the straps are latched, `out_en` is 0, `out_hiz` is 0, `out_refn` is 0 and `strap_status` is 0. The strap registers reset to code 000, so `freq_idx` reads 4.
- R2: Each pin passes through SYNC_STAGES flops. In the first cycle that the synchronized `pg_pd` is 1, the synchronized fs_a, fs_b, fs_c, itp, src5, ocdis and tsel straps are captured. They then stay fixed whatever the pins do until reset. `strap_status` bits, from bit 7 down to bit 0, are: latched, tsel, ocdis, src5, itp, fs_c, fs_b, fs_a.
- R3: `freq_idx` decodes the latched {fs_c,fs_b,fs_a} as 101→0 (100 MHz), 001→1 (133), 011→2 (166), 010→3 (200), 000→4 (266), 100→5 (333) and 110→6 (400). Code 111→7 is reserved, and for it `freq_rsvd` is 1.
- R4: After latching, outside test mode, a low synchronized `pg_pd` is a power-down request. It drives every enable to 0, whatever the stop inputs do. Raising the pin again does not re-latch the straps.
- R5: If tsel is latched 1, the block is in test mode. Power-down, stop and request inputs are ignored. With `tmode` high, every enable is 1 and `out_refn` is 1. With `tmode` low, every enable is 0 and `out_hiz` is 1.
- R6: If src5 is latched 1, `src5_mode` is 1, SRC5 is enabled and both stop inputs are ignored. If src5 is latched 0, SRC5 is disabled. A low `cpu_stop_n` then disables CPU0 and CPU1, and also the shared pair when it is in debug-clock mode. A low `pci_stop_n` disables PCI.
- R7: `itp_mode` equals the latched itp strap. With itp=1 the shared pair follows the CPU stop. With itp=0 it is SRC8 and follows request input F.
- R8: With `cr_mode` 1, the request pins take over SRC3 and SRC7, which are disabled. `cr_n` is active low: bit 0 gates SRC0 and SRC2, bit 1 gates SRC1 and SRC4, bit 2 gates SRC6, and bit 3 gates SRC8. With `cr_mode` 0, `cr_n` has no effect.
- R9: `out_en[i]` changes only at a clock edge where `out_low[i]` is 1; otherwise it holds.
- R10: The `out_en` and `out_low` bit order is: 0 CPU0, 1 CPU1, 2 shared pair (debug clock or SRC8), 3 to 10 SRC0 to SRC7, 11 PCI, 12 USB, 13 REF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset (power cycle) |
| pg_pd | input | 1 | Power-good strobe, then active-low power-down |
| fs_a | input | 1 | Frequency-select strap bit 0 |
| fs_b | input | 1 | Frequency-select strap bit 1 |
| fs_c | input | 1 | Frequency-select strap bit 2 |
| itp_strap | input | 1 | Shared pair is debug clock when 1 |
| src5_strap | input | 1 | Shared pins are SRC5 clock when 1 |
| ocdis_strap | input | 1 | Overclock-disable strap (status only) |
| tsel_strap | input | 1 | Test-mode entry strap |
| tmode | input | 1 | Test output select: 1 divided reference, 0 Hi-Z |
| cpu_stop_n | input | 1 | Active-low CPU clock stop |
| pci_stop_n | input | 1 | Active-low PCI clock stop |
| cr_n | input | 4 | Active-low clock requests A, B, E, F |
| cr_mode | input | 1 | Clock-request mode from register block |
| out_low | input | 14 | Per-output clock currently low |
| out_en | output | 14 | Per-output enable |
| out_hiz | output | 1 | All outputs high impedance |
| out_refn | output | 1 | Outputs driven from divided reference (REF stays REF) |
| freq_idx | output | 3 | CPU frequency index |
| freq_rsvd | output | 1 | Reserved frequency code latched |
| src5_mode | output | 1 | Shared pins are SRC5 clock |
| itp_mode | output | 1 | Shared pair is debug clock |
| strap_status | output | 8 | Latched straps for register read-back |

## Verification
The bench builds the block with SYNC_STAGES at its default of 2. This makes the latch, power-down and gating delays short, so every strap combination can be power-cycled in turn within a short run. The bench runs all eight frequency codes, both settings of each pin-mode strap, and test mode with the test pin both high and low. A pseudo-random `out_low` pattern, driven while the request inputs toggle, brings the hold-until-low rule into reach on every output bit.

// File: rtl/pgs_pkg.sv
`timescale 1ns/1ps
package pgs_pkg;
  localparam int NOUT      = 14;
  localparam int OI_CPU0   = 0;
  localparam int OI_CPU1   = 1;
  localparam int OI_PAIR   = 2;
  localparam int OI_SRC0   = 3;
  localparam int OI_PCI    = 11;
  localparam int NCR       = 4;

  localparam int NPIN      = 11 + NCR;
  localparam int PI_PG     = 0;
  localparam int PI_FSA    = 1;
  localparam int PI_TSEL   = 7;
  localparam int PI_TMODE  = 8;
  localparam int PI_CPUSTP = 9;
  localparam int PI_PCISTP = 10;
  localparam int PI_CR     = 11;

  typedef struct packed {
    logic       tsel;
    logic       ocdis;
    logic       src5;
    logic       itp;
    logic [2:0] fs;
  } straps_t;

  function automatic logic [2:0] freq_index(input logic [2:0] code);
    logic [2:0] idx;
    case (code)
      3'b101:  idx = 3'd0;
      3'b001:  idx = 3'd1;
      3'b011:  idx = 3'd2;
      3'b010:  idx = 3'd3;
      3'b000:  idx = 3'd4;
      3'b100:  idx = 3'd5;
      3'b110:  idx = 3'd6;
      default: idx = 3'd7;
    endcase
    return idx;
  endfunction
endpackage

// File: rtl/pgs_sync.sv
`timescale 1ns/1ps
module pgs_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pgs_strap_latch.sv
`timescale 1ns/1ps
module pgs_strap_latch
  import pgs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pg_s,
  input  straps_t    straps_in,
  output logic       latched,
  output straps_t    straps_q,
  output logic [2:0] freq_idx,
  output logic       freq_rsvd
);
  logic    latched_nx;
  logic    capture;
  straps_t straps_nx;

  always_comb begin
    capture    = !latched && pg_s;
    latched_nx = latched || pg_s;
    straps_nx  = capture ? straps_in : straps_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latched  <= 1'b0;
      straps_q <= '0;
    end else begin
      latched  <= latched_nx;
      if (capture) straps_q <= straps_nx;
    end
  end

  assign freq_idx  = freq_index(straps_q.fs);
  assign freq_rsvd = (freq_idx == 3'd7);

  // R2: once latched, the latch flag never drops before reset
  a_r2_latch_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    latched |=> latched);
  // R2: latched straps hold for the rest of the power cycle
  a_r2_straps_hold: assert property (@(posedge clk) disable iff (!rst_n)
    latched |=> $stable(straps_q));
endmodule

// File: rtl/pgs_enable_gate.sv
`timescale 1ns/1ps
module pgs_enable_gate
  import pgs_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            latched,
  input  logic            test_mode,
  input  logic            tmode_s,
  input  logic            pg_s,
  input  logic            src5,
  input  logic            itp,
  input  logic            cr_mode,
  input  logic            cpu_stop_n_s,
  input  logic            pci_stop_n_s,
  input  logic [NCR-1:0]  cr_n_s,
  input  logic [NOUT-1:0] out_low,
  output logic [NOUT-1:0] out_en,
  output logic            out_hiz,
  output logic            out_refn
);
  localparam int SRC1 = OI_SRC0 + 1;
  localparam int SRC2 = OI_SRC0 + 2;
  localparam int SRC3 = OI_SRC0 + 3;
  localparam int SRC4 = OI_SRC0 + 4;
  localparam int SRC5 = OI_SRC0 + 5;
  localparam int SRC6 = OI_SRC0 + 6;
  localparam int SRC7 = OI_SRC0 + 7;

  logic [NOUT-1:0] req;
  logic [NOUT-1:0] en_nx;
  logic            hiz_nx;
  logic            refn_nx;
  logic            pd;
  logic            cpu_stop;
  logic            pci_stop;

  assign pd       = !pg_s;
  assign cpu_stop = !src5 && !cpu_stop_n_s;
  assign pci_stop = !src5 && !pci_stop_n_s;

  always_comb begin
    req     = '0;
    hiz_nx  = 1'b0;
    refn_nx = 1'b0;
    if (!latched) begin
      req = '0;
    end else if (test_mode) begin
      if (tmode_s) begin
        req     = '1;
        refn_nx = 1'b1;
      end else begin
        hiz_nx  = 1'b1;
      end
    end else if (pd) begin
      req = '0;
    end else begin
      req = '1;
      if (!src5) req[SRC5] = 1'b0;
      if (cpu_stop) begin
        req[OI_CPU0] = 1'b0;
        req[OI_CPU1] = 1'b0;
        if (itp) req[OI_PAIR] = 1'b0;
      end
      if (pci_stop) req[OI_PCI] = 1'b0;
      if (cr_mode) begin
        req[SRC3] = 1'b0;
        req[SRC7] = 1'b0;
        if (!cr_n_s[0]) begin
          req[OI_SRC0] = 1'b0;
          req[SRC2]    = 1'b0;
        end
        if (!cr_n_s[1]) begin
          req[SRC1] = 1'b0;
          req[SRC4] = 1'b0;
        end
        if (!cr_n_s[2]) req[SRC6] = 1'b0;
        if (!cr_n_s[3] && !itp) req[OI_PAIR] = 1'b0;
      end
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < NOUT; gi++) begin : g_out
      assign en_nx[gi] = out_low[gi] ? req[gi] : out_en[gi];

      // R9: an enable only moves at a low boundary of its clock
      a_r9_hold_until_low: assert property (@(posedge clk) disable iff (!rst_n)
        !out_low[gi] |=> $stable(out_en[gi]));
      // R4: power-down drives each enable off at its next low boundary
      a_r4_pd_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
        (latched && !test_mode && pd && out_low[gi]) |=> !out_en[gi]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_en   <= '0;
      out_hiz  <= 1'b0;
      out_refn <= 1'b0;
    end else begin
      out_en   <= en_nx;
      out_hiz  <= hiz_nx;
      out_refn <= refn_nx;
    end
  end

  // R1: nothing is enabled or floated before the straps are latched
  a_r1_idle_before_latch: assert property (@(posedge clk) disable iff (!rst_n)
    !latched |=> (out_en == '0) && !out_hiz && !out_refn);
  // R6: with the shared pins used as stop inputs, SRC5 is turned off
  a_r6_src5_off_in_stop_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (latched && !test_mode && !src5 && out_low[SRC5]) |=> !out_en[SRC5]);
endmodule

// File: rtl/pgs_strap_ctrl.sv
`timescale 1ns/1ps
module pgs_strap_ctrl
  import pgs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pg_pd,
  input  logic            fs_a,
  input  logic            fs_b,
  input  logic            fs_c,
  input  logic            itp_strap,
  input  logic            src5_strap,
  input  logic            ocdis_strap,
  input  logic            tsel_strap,
  input  logic            tmode,
  input  logic            cpu_stop_n,
  input  logic            pci_stop_n,
  input  logic [3:0]      cr_n,
  input  logic            cr_mode,
  input  logic [13:0]     out_low,
  output logic [13:0]     out_en,
  output logic            out_hiz,
  output logic            out_refn,
  output logic [2:0]      freq_idx,
  output logic            freq_rsvd,
  output logic            src5_mode,
  output logic            itp_mode,
  output logic [7:0]      strap_status
);
  logic [NPIN-1:0] pins_raw;
  logic [NPIN-1:0] pins_s;
  straps_t         straps_in;
  straps_t         straps_q;
  logic            latched;

  assign pins_raw = {cr_n, pci_stop_n, cpu_stop_n, tmode, tsel_strap, ocdis_strap,
                     src5_strap, itp_strap, fs_c, fs_b, fs_a, pg_pd};

  pgs_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pins_raw),
    .q     (pins_s)
  );

  assign straps_in = straps_t'(pins_s[PI_TSEL:PI_FSA]);

  pgs_strap_latch u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .pg_s      (pins_s[PI_PG]),
    .straps_in (straps_in),
    .latched   (latched),
    .straps_q  (straps_q),
    .freq_idx  (freq_idx),
    .freq_rsvd (freq_rsvd)
  );

  pgs_enable_gate u_gate (
    .clk          (clk),
    .rst_n        (rst_n),
    .latched      (latched),
    .test_mode    (straps_q.tsel),
    .tmode_s      (pins_s[PI_TMODE]),
    .pg_s         (pins_s[PI_PG]),
    .src5         (straps_q.src5),
    .itp          (straps_q.itp),
    .cr_mode      (cr_mode),
    .cpu_stop_n_s (pins_s[PI_CPUSTP]),
    .pci_stop_n_s (pins_s[PI_PCISTP]),
    .cr_n_s       (pins_s[PI_CR +: NCR]),
    .out_low      (out_low),
    .out_en       (out_en),
    .out_hiz      (out_hiz),
    .out_refn     (out_refn)
  );

  assign src5_mode    = straps_q.src5;
  assign itp_mode     = straps_q.itp;
  assign strap_status = {latched, straps_q};
endmodule

// File: tb/tb_pgs_strap_ctrl.sv
`timescale 1ns/1ps
module tb_pgs_strap_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pg_pd, fs_a, fs_b, fs_c, itp_strap, src5_strap, ocdis_strap, tsel_strap;
  logic        tmode, cpu_stop_n, pci_stop_n, cr_mode;
  logic [3:0]  cr_n;
  logic [13:0] out_low;
  logic [13:0] out_en;
  logic        out_hiz, out_refn, freq_rsvd, src5_mode, itp_mode;
  logic [2:0]  freq_idx;
  logic [7:0]  strap_status;

  pgs_strap_ctrl dut (
    .clk(clk), .rst_n(rst_n), .pg_pd(pg_pd), .fs_a(fs_a), .fs_b(fs_b), .fs_c(fs_c),
    .itp_strap(itp_strap), .src5_strap(src5_strap), .ocdis_strap(ocdis_strap),
    .tsel_strap(tsel_strap), .tmode(tmode), .cpu_stop_n(cpu_stop_n),
    .pci_stop_n(pci_stop_n), .cr_n(cr_n), .cr_mode(cr_mode), .out_low(out_low),
    .out_en(out_en), .out_hiz(out_hiz), .out_refn(out_refn), .freq_idx(freq_idx),
    .freq_rsvd(freq_rsvd), .src5_mode(src5_mode), .itp_mode(itp_mode),
    .strap_status(strap_status)
  );

  always #5 clk = ~clk;

  int    vectors = 0;
  int    miscompares = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  // reference model state
  logic [14:0] pinvec;
  logic [14:0] m_q [$];
  logic        m_lat;
  logic [6:0]  m_str;
  logic [13:0] m_en;
  logic        m_hiz, m_refn;

  assign pinvec = {cr_n, pci_stop_n, cpu_stop_n, tmode, tsel_strap, ocdis_strap,
                   src5_strap, itp_strap, fs_c, fs_b, fs_a, pg_pd};

  // bits of s: 0 pg, 8 tmode, 9 cpu stop, 10 pci stop, 11..14 cr A,B,E,F
  // bits of st: 6 tsel, 4 src5, 3 itp
  function automatic logic [13:0] f_req(input logic lat, input logic [6:0] st,
      input logic [14:0] s, input logic crm, output logic hz, output logic rf);
    logic [13:0] r;
    r = '0; hz = 1'b0; rf = 1'b0;
    if (!lat) r = '0;
    else if (st[6]) begin
      if (s[8]) begin r = '1; rf = 1'b1; end
      else hz = 1'b1;
    end else if (!s[0]) r = '0;
    else begin
      r = '1;
      if (!st[4]) begin
        r[8] = 1'b0;
        if (!s[9]) begin r[0] = 1'b0; r[1] = 1'b0; if (st[3]) r[2] = 1'b0; end
        if (!s[10]) r[11] = 1'b0;
      end
      if (crm) begin
        r[6] = 1'b0; r[10] = 1'b0;
        if (!s[11]) begin r[3] = 1'b0; r[5] = 1'b0; end
        if (!s[12]) begin r[4] = 1'b0; r[7] = 1'b0; end
        if (!s[13]) r[9] = 1'b0;
        if (!s[14] && !st[3]) r[2] = 1'b0;
      end
    end
    return r;
  endfunction

  function automatic logic [2:0] f_idx(input logic [2:0] code);
    int mhz;
    case (code)
      3'b101: mhz = 100; 3'b001: mhz = 133; 3'b011: mhz = 166; 3'b010: mhz = 200;
      3'b000: mhz = 266; 3'b100: mhz = 333; 3'b110: mhz = 400; default: mhz = 0;
    endcase
    case (mhz)
      100: return 3'd0; 133: return 3'd1; 166: return 3'd2; 200: return 3'd3;
      266: return 3'd4; 333: return 3'd5; 400: return 3'd6; default: return 3'd7;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    logic [13:0] r;
    logic        hz, rf;
    logic [14:0] s2;
    if (!rst_n) begin
      m_q = {15'd0, 15'd0};
      m_lat = 1'b0; m_str = '0; m_en = '0; m_hiz = 1'b0; m_refn = 1'b0;
    end else begin
      s2 = m_q[1];
      r  = f_req(m_lat, m_str, s2, cr_mode, hz, rf);
      for (int i = 0; i < 14; i++) if (out_low[i]) m_en[i] = r[i];
      m_hiz  = hz;
      m_refn = rf;
      if (!m_lat && s2[0]) begin m_lat = 1'b1; m_str = s2[7:1]; end
      m_q.push_front(pinvec);
      void'(m_q.pop_back());
    end
  end

  task automatic chk(input string f, input logic [15:0] a, input logic [15:0] e);
    if (a !== e) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", cur_req, f, a, e, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      vectors++;
      chk("out_en", 16'(out_en), 16'(m_en));
      chk("out_hiz", 16'(out_hiz), 16'(m_hiz));
      chk("out_refn", 16'(out_refn), 16'(m_refn));
      chk("freq_idx", 16'(freq_idx), 16'(f_idx(m_str[2:0])));
      chk("freq_rsvd", 16'(freq_rsvd), 16'(m_str[2:0] == 3'b111));
      chk("src5_mode", 16'(src5_mode), 16'(m_str[4]));
      chk("itp_mode", 16'(itp_mode), 16'(m_str[3]));
      chk("strap_status", 16'(strap_status), 16'({m_lat, m_str}));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic power_up(input logic [2:0] fs, input logic itp, input logic s5,
                          input logic oc, input logic ts);
    rst_n = 1'b0; pg_pd = 1'b0;
    {fs_c, fs_b, fs_a} = fs;
    itp_strap = itp; src5_strap = s5; ocdis_strap = oc; tsel_strap = ts;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    pg_pd = 1'b1;
    tick(6);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  logic [15:0] lf;

  initial begin
    rst_n = 1'b0; pg_pd = 1'b0; fs_a = 0; fs_b = 0; fs_c = 0;
    itp_strap = 0; src5_strap = 1; ocdis_strap = 0; tsel_strap = 0;
    tmode = 0; cpu_stop_n = 1; pci_stop_n = 1; cr_n = 4'hF; cr_mode = 0;
    out_low = '1;
    cur_req = "R1";           // reset state
    tick(5);
    rst_n = 1'b1;
    tick(4);                  // R1: straps unlatched, everything idle

    cur_req = "R2";           // first latch, then strap pins wiggle
    power_up(3'b011, 1'b1, 1'b1, 1'b1, 1'b0);
    {fs_c, fs_b, fs_a} = 3'b100; itp_strap = 0; src5_strap = 0; ocdis_strap = 0;
    tick(6);

    cur_req = "R3";           // every frequency code
    for (int c = 0; c < 8; c++) begin
      power_up(3'(c), 1'b0, 1'b1, 1'b0, 1'b0);
      tick(2);
    end

    cur_req = "R4";           // power-down, then pin high again with new straps
    power_up(3'b010, 1'b0, 1'b0, 1'b0, 1'b0);
    cpu_stop_n = 1'b0;
    pg_pd = 1'b0;
    tick(6);
    cpu_stop_n = 1'b1;
    {fs_c, fs_b, fs_a} = 3'b111; tsel_strap = 1'b1;
    pg_pd = 1'b1;
    tick(6);

    cur_req = "R6";           // stop inputs active in stop mode
    power_up(3'b101, 1'b1, 1'b0, 1'b0, 1'b0);
    cpu_stop_n = 1'b0; tick(5);
    pci_stop_n = 1'b0; tick(5);
    cpu_stop_n = 1'b1; tick(5);
    pci_stop_n = 1'b1; tick(5);
    cur_req = "R6";           // SRC5 mode: stops ignored
    power_up(3'b101, 1'b1, 1'b1, 1'b0, 1'b0);
    cpu_stop_n = 1'b0; pci_stop_n = 1'b0; tick(6);
    cpu_stop_n = 1'b1; pci_stop_n = 1'b1; tick(2);

    cur_req = "R10";          // CPU stop shows on bits 0 and 1 only, itp=0
    power_up(3'b101, 1'b0, 1'b0, 1'b0, 1'b0);
    cpu_stop_n = 1'b0; tick(6);
    cpu_stop_n = 1'b1; tick(4);

    cur_req = "R7";           // shared pair as SRC8 follows request F
    cr_mode = 1'b1;
    cr_n = 4'b0111; tick(6);
    cr_n = 4'hF; tick(4);
    power_up(3'b101, 1'b1, 1'b1, 1'b0, 1'b0);
    cr_n = 4'b0111; tick(6);  // debug clock: request F has no effect
    cr_n = 4'hF; cr_mode = 1'b0; tick(2);

    cur_req = "R8";           // request walk, then mode off
    power_up(3'b001, 1'b0, 1'b1, 1'b0, 1'b0);
    cr_mode = 1'b1;
    for (int k = 0; k < 16; k++) begin
      cr_n = 4'(k);
      tick(4);
    end
    cr_mode = 1'b0; cr_n = 4'h0; tick(6);
    cr_n = 4'hF; tick(2);

    cur_req = "R9";           // enables move only on low boundaries
    cr_mode = 1'b1;
    lf = 16'hACE1;
    for (int k = 0; k < 300; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      out_low = lf[13:0];
      if (k % 7 == 0) cr_n = lf[7:4];
      if (k % 11 == 0) pg_pd = ~pg_pd;
      tick(1);
    end
    out_low = '1; cr_mode = 1'b0; cr_n = 4'hF; pg_pd = 1'b1; tick(4);

    cur_req = "R5";           // test mode
    tmode = 1'b1;
    power_up(3'b110, 1'b0, 1'b0, 1'b0, 1'b1);
    cpu_stop_n = 1'b0; pg_pd = 1'b0; cr_mode = 1'b1; cr_n = 4'h0; tick(6);
    tmode = 1'b0; tick(6);
    tmode = 1'b1; tick(6);
    cpu_stop_n = 1'b1; pg_pd = 1'b1; cr_mode = 1'b0; cr_n = 4'hF; tick(3);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule